// File: doc/BRIEF.md
# Power-up memory initialization sequencer

After reset is released, this block runs a fixed-length boot sequence. During the sequence it loads a parameter RAM from a read-only boot table and fills a separate data RAM with zeros. Both memories are small arrays inside the block. One free-running address counter drives both fills. The boot table has one cycle of read latency, so the parameter write follows the table read by one cycle.

A host register port reads and writes either memory once the sequence is over. While the sequence runs, `busy_o` is high and every host access is refused. A refused write is dropped. A refused read returns zero and raises an error flag. If reset is asserted again during the sequence, the sequence stops at once, and the next reset release starts it again from address zero.

Top module: `boot_mem_init`

## Requirements
- R1: While `rst_ni` is low, `busy_o` is 1, `host_rvalid_o` and `host_err_o` are 0, and the address counter is held at zero.
- R2: After `rst_ni` rises, `busy_o` stays 1 for exactly 1024 rising clock edges. It falls on the 1024th edge and stays 0 until the next reset.
- R3: When the sequence ends, parameter RAM word a holds the boot table value ((a × 40503) mod 65536) XOR 0x5A5A, for every a below P_DEPTH. This holds whatever the RAM held before the sequence.
- R4: When the sequence ends, every data RAM word is zero, whatever it held before the sequence.
- R5: A host write (`host_req_i`=1, `host_we_i`=1) presented while `busy_o` is 1 changes neither memory.
- R6: A host read presented while `busy_o` is 1 is answered one edge later with `host_rvalid_o`=1, `host_err_o`=1 and `host_rdata_o`=0.
- R7: A reset asserted in the middle of the sequence aborts it at once. The next release starts a full 1024-edge sequence from address zero, and that sequence reloads both memories completely.
- R8: Once `busy_o` is 0, a host write takes effect at the edge that samples it. A host read is answered at the next edge with `host_rvalid_o`=1, `host_err_o`=0 and the stored word. `host_sel_i`=0 selects the parameter RAM and 1 selects the data RAM.
- R9: Both fills take their address from one shared counter. A memory smaller than 1024 words uses the low counter bits. Its boot writes happen only while the counter is below its depth, and each parameter write lands one cycle after its table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the sequence |
| host_req_i | input | 1 | Host access request, one cycle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = parameter RAM, 1 = data RAM |
| host_addr_i | input | $clog2(P_DEPTH) | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Read data; zero on a refused read |
| host_rvalid_o | output | 1 | Read response strobe, one edge after the request |
| host_err_o | output | 1 | Access refused because the sequence was running |
| busy_o | output | 1 | Boot sequence in progress |

## Verification
Reset release is driven on a falling clock edge. The bench then counts rising edges: `busy_o` is sampled at the falling edge after the 1023rd rising edge, where it must still be 1, and again after the 1024th, where it must be 0. Each host request is set up on a falling edge and sampled by the next rising edge. Its response registers are read at the falling edge that follows, so every read result and refusal flag is checked exactly one edge after its request. The memory contents that result from the sequence are checked only after `busy_o` has fallen, by read-back through the host port. This covers the one-cycle parameter write lag and the refused writes made in mid-sequence.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic {SEL_PARAM = 1'b0, SEL_DATA = 1'b1} mem_sel_e;

  // boot table contents, low DW bits used
  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return (a * 32'd40503) ^ 32'h0000_5A5A;
  endfunction
endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl #(
  parameter int CYCLES = 1024,
  localparam int CW = $clog2(CYCLES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(CYCLES - 1)) busy_q <= 1'b0;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;

  a_r2_busy_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !busy_q);
  a_r2_fall_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == CW'(CYCLES - 1)));
  a_r9_cnt_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != CW'(CYCLES - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/boot_rom.sv
module boot_rom #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) rd_q <= DW'(boot_pkg::rom_word(32'(addr_i)));

  assign rdata_o = rd_q;
endmodule

// File: rtl/boot_ram.sv
module boot_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) if (we_i) mem[waddr_i] <= wdata_i;

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/boot_mem_init.sv
module boot_mem_init #(
  parameter int CYCLES  = 1024,
  parameter int P_DEPTH = 64,
  parameter int D_DEPTH = 32,
  parameter int DW      = 16,
  localparam int CW     = $clog2(CYCLES),
  localparam int PAW    = $clog2(P_DEPTH),
  localparam int DAW    = $clog2(D_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_req_i,
  input  logic           host_we_i,
  input  logic           host_sel_i,
  input  logic [PAW-1:0] host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  output logic [DW-1:0]  host_rdata_o,
  output logic           host_rvalid_o,
  output logic           host_err_o,
  output logic           busy_o
);
  import boot_pkg::*;

  logic [CW-1:0]  cnt;
  logic           busy;
  logic [DW-1:0]  rom_q;
  logic           p_fill, d_fill, p_fill_q;
  logic [PAW-1:0] p_addr_q;
  logic           host_ok, host_wr_p, host_wr_d;
  mem_sel_e       sel;
  logic           p_we, d_we;
  logic [PAW-1:0] p_waddr;
  logic [DAW-1:0] d_waddr;
  logic [DW-1:0]  p_wdata, d_wdata, p_rd, d_rd;
  logic [DW-1:0]  rdata_q;
  logic           rvalid_q, err_q;

  boot_ctrl #(.CYCLES(CYCLES)) u_ctrl (
    .clk_i, .rst_ni, .cnt_o(cnt), .busy_o(busy)
  );

  boot_rom #(.DEPTH(P_DEPTH), .DW(DW)) u_rom (
    .clk_i, .addr_i(cnt[PAW-1:0]), .rdata_o(rom_q)
  );

  // fills share the counter; each stops at its own depth
  assign p_fill = busy && (32'(cnt) < P_DEPTH);
  assign d_fill = busy && (32'(cnt) < D_DEPTH);

  // table data arrives one cycle after its address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_fill_q <= 1'b0;
      p_addr_q <= '0;
    end else begin
      p_fill_q <= p_fill;
      p_addr_q <= cnt[PAW-1:0];
    end
  end

  assign sel       = mem_sel_e'(host_sel_i);
  assign host_ok   = host_req_i && !busy;
  assign host_wr_p = host_ok && host_we_i && (sel == SEL_PARAM);
  assign host_wr_d = host_ok && host_we_i && (sel == SEL_DATA);

  assign p_we    = p_fill_q || host_wr_p;
  assign p_waddr = p_fill_q ? p_addr_q : host_addr_i;
  assign p_wdata = p_fill_q ? rom_q    : host_wdata_i;

  assign d_we    = d_fill || host_wr_d;
  assign d_waddr = busy ? cnt[DAW-1:0] : host_addr_i[DAW-1:0];
  assign d_wdata = busy ? '0 : host_wdata_i;

  boot_ram #(.DEPTH(P_DEPTH), .DW(DW)) u_pram (
    .clk_i, .we_i(p_we), .waddr_i(p_waddr), .wdata_i(p_wdata),
    .raddr_i(host_addr_i), .rdata_o(p_rd)
  );

  boot_ram #(.DEPTH(D_DEPTH), .DW(DW)) u_dram (
    .clk_i, .we_i(d_we), .waddr_i(d_waddr), .wdata_i(d_wdata),
    .raddr_i(host_addr_i[DAW-1:0]), .rdata_o(d_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= host_req_i && !host_we_i;
      err_q    <= host_req_i && busy;
      if (host_ok && !host_we_i) rdata_q <= (sel == SEL_DATA) ? d_rd : p_rd;
      else                       rdata_q <= '0;
    end
  end

  assign host_rdata_o  = rdata_q;
  assign host_rvalid_o = rvalid_q;
  assign host_err_o    = err_q;
  assign busy_o        = busy;

  a_r5_no_host_data_in_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && d_we) |-> (d_wdata == '0));
  a_r6_err_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |-> $past(busy));
  a_r6_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |-> (host_rdata_o == '0));
  a_r9_pwrite_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_fill_q |-> ($past(busy) && (32'($past(cnt)) < P_DEPTH)));
endmodule

// File: tb/boot_mem_init_test.sv
`timescale 1ns/1ps
module boot_mem_init_test;
  localparam int CYC = 1024, PD = 64, DD = 32, DW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, sel = 1'b0;
  logic [5:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, err, busy;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  boot_mem_init uut (
    .clk_i(clk), .rst_ni(rst_ni), .host_req_i(req), .host_we_i(we),
    .host_sel_i(sel), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_rvalid_o(rvalid), .host_err_o(err), .busy_o(busy)
  );

  function automatic logic [DW-1:0] exp_rom(int a);
    logic [31:0] p;
    p = 32'(a) * 32'd40503;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  task automatic release_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_done();
    repeat (CYC + 4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwrite(logic s, int a, logic [DW-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; sel = s; addr = 6'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic hread(logic s, int a, output logic [DW-1:0] d, output logic e, output logic v);
    @(negedge clk); req = 1'b1; we = 1'b0; sel = s; addr = 6'(a);
    @(negedge clk); d = rdata; e = err; v = rvalid; req = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R1 rvalid in reset", rvalid, 0);
    chk("R1 err in reset", err, 0);
    rst_ni = 1'b1;
    // a zero counter gives the full window
    repeat (CYC - 1) @(posedge clk);
    @(negedge clk); chk("R1 counter starts at zero", busy, 1);
    wait_done();
  endtask

  task automatic t_boot_length();
    release_reset();
    repeat (CYC - 1) @(posedge clk);
    @(negedge clk); chk("R2 busy at edge 1023", busy, 1);
    @(posedge clk);
    @(negedge clk); chk("R2 busy low at edge 1024", busy, 0);
    repeat (20) @(negedge clk);
    chk("R2 busy stays low", busy, 0);
  endtask

  task automatic t_scribble();
    for (int a = 0; a < PD; a++) hwrite(1'b0, a, 16'hFFFF ^ 16'(a));
    for (int a = 0; a < DD; a++) hwrite(1'b1, a, 16'hA500 | 16'(a));
  endtask

  task automatic t_host_idle();
    logic [DW-1:0] d; logic e, v;
    hwrite(1'b0, 7, 16'h1234);
    hread(1'b0, 7, d, e, v);
    chk("R8 param readback", d, 16'h1234);
    chk("R8 rvalid", v, 1);
    chk("R8 no err", e, 0);
    hwrite(1'b1, 31, 16'hBEEF);
    hread(1'b1, 31, d, e, v);
    chk("R8 data readback", d, 16'hBEEF);
    hread(1'b0, 31, d, e, v);
    chk("R8 sel isolates", d, exp_rom(31));
  endtask

  task automatic t_load_and_clear(string tag);
    logic [DW-1:0] d; logic e, v;
    for (int a = 0; a < PD; a++) begin
      hread(1'b0, a, d, e, v);
      chk({tag, " R3 param word"}, d, exp_rom(a));
    end
    for (int a = 0; a < DD; a++) begin
      hread(1'b1, a, d, e, v);
      chk({tag, " R4 data zero"}, d, 0);
    end
  endtask

  task automatic t_busy_refuse();
    logic [DW-1:0] d; logic e, v;
    release_reset();
    repeat (100) @(negedge clk);
    hwrite(1'b0, 3, 16'hDEAD);   // after addr 3 loaded
    hwrite(1'b1, 5, 16'hCAFE);   // after addr 5 cleared
    hread(1'b0, 3, d, e, v);
    chk("R6 refused read data", d, 0);
    chk("R6 refused read err", e, 1);
    chk("R6 refused read rvalid", v, 1);
    wait_done();
    hread(1'b0, 3, d, e, v);
    chk("R5 param write dropped", d, exp_rom(3));
    hread(1'b1, 5, d, e, v);
    chk("R5 data write dropped", d, 0);
  endtask

  task automatic t_abort();
    release_reset();
    repeat (500) @(negedge clk);
    rst_ni = 1'b0;
    #0.5;
    chk("R7 abort busy", busy, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (CYC - 1) @(posedge clk);
    @(negedge clk); chk("R7 restart full window", busy, 1);
    @(posedge clk);
    @(negedge clk); chk("R7 restart ends", busy, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_boot_length();
    t_host_idle();
    t_scribble();
    release_reset();
    wait_done();
    t_load_and_clear("reboot");
    t_busy_refuse();
    t_scribble();
    t_abort();
    t_load_and_clear("after abort R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule